// File: doc/BRIEF.md
# Processor Status Register with Flag Generator

This block holds the 8-bit status word of a small accumulator-style processor. Three bits select the data-memory bank. Two bits report power and watchdog events. Three bits are the arithmetic flags: zero, digit carry and carry. The block computes the carry and digit-carry flags itself from the ALU operands and the operation kind. It takes the zero flag from the ALU result.

Software can write the register over the data bus. The flag logic takes priority over such a write. Whenever the current instruction updates any arithmetic flag, the bus data for all three flag bits is discarded. Flags that are not being updated hold their value. The two event bits cannot be written from the bus; only event strobes change them.

The block also forms the 9-bit data-memory address. In direct mode it places the two direct bank bits above a 7-bit address. In indirect mode it places the indirect bank bit above an 8-bit pointer.

Top module: `proc_status`

## Requirements
- R1: While `rst_n` is low and after it rises, status bits [7:5] read 000 and bits [4:3] read 11; bits [2:0] are undefined until first written.
- R2: With `bus_we` high, status bits [7:5] take `bus_wdata[7:5]` at the next edge; bits [2:0] take `bus_wdata[2:0]` only when none of `upd_z`, `upd_dc`, `upd_c` is high.
- R3: Bus writes never change status bits [4:3].
- R4: When any of `upd_z`, `upd_dc`, `upd_c` is high, the bus data for bits [2:0] is discarded. A bus write of 00h together with a zero result and only `upd_z` high leaves 000 in [7:5], [4:3] unchanged, 1 in bit 2, and bits [1:0] unchanged.
- R5: With `alu_kind` 0 (add), `upd_c` loads bit 0 with the carry out of bit 7 of a+b, and `upd_dc` loads bit 1 with the carry out of bit 3.
- R6: With `alu_kind` 1 (subtract a−b, done as a + ~b + 1), bit 0 is 1 exactly when a ≥ b, and bit 1 is 1 exactly when a[3:0] ≥ b[3:0] (active-low borrow).
- R7: With `alu_kind` 3 (rotate left), `upd_c` loads bit 0 from `alu_a[7]`. With `alu_kind` 4 (rotate right), it loads bit 0 from `alu_a[0]`. For kinds 2 to 4 `upd_dc` holds bit 1, and for kind 2 (logic) `upd_c` holds bit 0.
- R8: `upd_z` loads bit 2 with 1 when `alu_res` is zero and with 0 otherwise, for every operation kind.
- R9: Bit 4 (timeout) goes to 0 on `wdt_tmo`. Otherwise it goes to 1 on `wdt_clr` or `sleep`. A timeout beats a clear in the same cycle.
- R10: Bit 3 (power-down) goes to 0 on `sleep`. Otherwise it goes to 1 on `wdt_clr`. Sleep beats a clear in the same cycle.
- R11: `mem_addr` is {bit 7, `ind_ptr`} when `ind_sel` is 1, and {bits [6:5], `dir_addr`} when `ind_sel` is 0, in the same cycle.
- R12: A flag bit whose update strobe is low and that receives no bus write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_we | input | 1 | Data-bus write to the status register |
| bus_wdata | input | 8 | Data-bus write value |
| alu_kind | input | 3 | Operation kind: 0 add, 1 subtract, 2 logic, 3 rotate left, 4 rotate right |
| alu_a | input | 8 | First ALU operand |
| alu_b | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result, used for the zero flag |
| upd_z | input | 1 | Instruction updates the zero flag |
| upd_dc | input | 1 | Instruction updates the digit-carry flag |
| upd_c | input | 1 | Instruction updates the carry flag |
| wdt_clr | input | 1 | Watchdog-clear instruction executed |
| sleep | input | 1 | Sleep instruction executed |
| wdt_tmo | input | 1 | Watchdog timeout |
| ind_sel | input | 1 | Select indirect addressing |
| dir_addr | input | DIR_W | Direct address within a bank |
| ind_ptr | input | DIR_W+1 | Indirect pointer |
| status_q | output | 8 | Status register value |
| mem_addr | output | DIR_W+2 | Data-memory address |

## Verification
The assertions assume every input is a known 0 or 1 at each sampling edge. They also assume `alu_res` is the value whose zero test the flag must report. Event strobes may coincide in any combination, and the properties encode the priorities given above.

The bench drives all inputs on the falling edge, so they are settled at the rising edge. It uses `alu_kind` only in the range 0 to 4. It computes `alu_res` from the operands, so the result is consistent with the kind. Flag bits are compared only after the reference model has seen them written.

// File: rtl/proc_status.sv
module proc_status #(
  parameter int DIR_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [7:0]         bus_wdata,
  input  logic [2:0]         alu_kind,
  input  logic [7:0]         alu_a,
  input  logic [7:0]         alu_b,
  input  logic [7:0]         alu_res,
  input  logic               upd_z,
  input  logic               upd_dc,
  input  logic               upd_c,
  input  logic               wdt_clr,
  input  logic               sleep,
  input  logic               wdt_tmo,
  input  logic               ind_sel,
  input  logic [DIR_W-1:0]   dir_addr,
  input  logic [DIR_W:0]     ind_ptr,
  output logic [7:0]         status_q,
  output logic [DIR_W+1:0]   mem_addr
);
  localparam logic [2:0] K_ADD = 3'd0;
  localparam logic [2:0] K_SUB = 3'd1;
  localparam logic [2:0] K_RL  = 3'd3;
  localparam logic [2:0] K_RR  = 3'd4;

  logic [2:0] bank_q;
  logic       to_q, pd_q, z_q, dc_q, c_q;

  logic       is_sub, is_arith, flag_lock;
  logic [7:0] b_eff;
  logic [8:0] sum_full;
  logic [4:0] sum_nib;
  logic       z_nx, dc_nx, c_nx;

  assign is_sub   = (alu_kind == K_SUB);
  assign is_arith = (alu_kind == K_ADD) || is_sub;
  assign b_eff    = is_sub ? ~alu_b : alu_b;
  assign sum_full = {1'b0, alu_a} + {1'b0, b_eff} + {8'd0, is_sub};
  assign sum_nib  = {1'b0, alu_a[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, is_sub};
  assign flag_lock = upd_z | upd_dc | upd_c;

  always_comb begin
    z_nx  = z_q;
    dc_nx = dc_q;
    c_nx  = c_q;
    if (!flag_lock && bus_we) begin
      z_nx  = bus_wdata[2];
      dc_nx = bus_wdata[1];
      c_nx  = bus_wdata[0];
    end
    if (upd_z)
      z_nx = (alu_res == 8'd0);
    if (upd_dc && is_arith)
      dc_nx = sum_nib[4];
    if (upd_c) begin
      if (is_arith)
        c_nx = sum_full[8];
      else if (alu_kind == K_RL)
        c_nx = alu_a[7];
      else if (alu_kind == K_RR)
        c_nx = alu_a[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 3'b000;
      to_q   <= 1'b1;
      pd_q   <= 1'b1;
    end else begin
      if (bus_we)
        bank_q <= bus_wdata[7:5];
      if (wdt_tmo)
        to_q <= 1'b0;
      else if (wdt_clr || sleep)
        to_q <= 1'b1;
      if (sleep)
        pd_q <= 1'b0;
      else if (wdt_clr)
        pd_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    z_q  <= z_nx;
    dc_q <= dc_nx;
    c_q  <= c_nx;
  end

  assign status_q = {bank_q, to_q, pd_q, z_q, dc_q, c_q};
  assign mem_addr = ind_sel ? {bank_q[2], ind_ptr} : {bank_q[1:0], dir_addr};
endmodule

module proc_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] alu_res,
  input logic       upd_z,
  input logic       upd_dc,
  input logic       upd_c,
  input logic       wdt_clr,
  input logic       sleep,
  input logic       wdt_tmo,
  input logic [7:0] status_q
);
  p_bank_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> status_q[7:5] == $past(bus_wdata[7:5]));
  p_event_bits_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_clr || sleep || wdt_tmo) |=> $stable(status_q[4:3]));
  p_lock_holds_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_z || upd_dc) && !upd_c |=> $stable(status_q[0]));
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_z |=> status_q[2] == ($past(alu_res) == 8'd0));
  p_tmo_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tmo |=> !status_q[4]);
  p_clr_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr || sleep) && !wdt_tmo |=> status_q[4]);
  p_sleep_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !status_q[3]);
  p_clr_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr && !sleep |=> status_q[3]);
  p_c_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_c && !bus_we |=> $stable(status_q[0]));
endmodule

bind proc_status proc_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .alu_res(alu_res), .upd_z(upd_z), .upd_dc(upd_dc), .upd_c(upd_c),
  .wdt_clr(wdt_clr), .sleep(sleep), .wdt_tmo(wdt_tmo), .status_q(status_q)
);

// File: tb/sim_proc_status.sv
`timescale 1ns/1ps
module sim_proc_status;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_we = 0, upd_z = 0, upd_dc = 0, upd_c = 0;
  logic       wdt_clr = 0, sleep = 0, wdt_tmo = 0, ind_sel = 0;
  logic [7:0] bus_wdata = 0, alu_a = 0, alu_b = 0, alu_res = 0, ind_ptr = 0;
  logic [2:0] alu_kind = 0;
  logic [6:0] dir_addr = 0;
  logic [7:0] status_q;
  logic [8:0] mem_addr;

  proc_status u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .alu_kind(alu_kind), .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
    .upd_z(upd_z), .upd_dc(upd_dc), .upd_c(upd_c), .wdt_clr(wdt_clr),
    .sleep(sleep), .wdt_tmo(wdt_tmo), .ind_sel(ind_sel), .dir_addr(dir_addr),
    .ind_ptr(ind_ptr), .status_q(status_q), .mem_addr(mem_addr)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [2:0] m_bank = 3'b000;
  logic m_to = 1, m_pd = 1, m_z = 0, m_dc = 0, m_c = 0;
  logic k_z = 0, k_dc = 0, k_c = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp_status();
    chk({cur_tag, " bank"}, int'(status_q[7:5]), int'(m_bank));
    chk({cur_tag, " timeout"}, int'(status_q[4]), int'(m_to));
    chk({cur_tag, " powerdown"}, int'(status_q[3]), int'(m_pd));
    if (k_z)  chk({cur_tag, " zero"}, int'(status_q[2]), int'(m_z));
    if (k_dc) chk({cur_tag, " digitcarry"}, int'(status_q[1]), int'(m_dc));
    if (k_c)  chk({cur_tag, " carry"}, int'(status_q[0]), int'(m_c));
  endtask

  task automatic cyc(string tag, logic we, logic [7:0] wd, logic [2:0] kind,
                     logic [7:0] a, logic [7:0] b, logic uz, logic udc, logic uc,
                     logic clr, logic slp, logic tmo, logic isel,
                     logic [6:0] da, logic [7:0] pt);
    logic [7:0] r;
    int sa, sb;
    @(negedge clk);
    cmp_status();
    case (kind)
      3'd0: r = a + b;
      3'd1: r = a - b;
      3'd2: r = a & b;
      3'd3: r = {a[6:0], 1'b0};
      3'd4: r = {1'b0, a[7:1]};
      default: r = a;
    endcase
    bus_we = we; bus_wdata = wd; alu_kind = kind; alu_a = a; alu_b = b;
    alu_res = r; upd_z = uz; upd_dc = udc; upd_c = uc; wdt_clr = clr;
    sleep = slp; wdt_tmo = tmo; ind_sel = isel; dir_addr = da; ind_ptr = pt;
    #1;
    chk({tag, " R11 addr"}, int'(mem_addr),
        isel ? int'({m_bank[2], pt}) : int'({m_bank[1:0], da}));
    sa = int'(a); sb = int'(b);
    if (we && !(uz || udc || uc)) begin
      m_z = wd[2]; m_dc = wd[1]; m_c = wd[0];
      k_z = 1; k_dc = 1; k_c = 1;
    end
    if (we) m_bank = wd[7:5];
    if (uz) begin m_z = (r == 8'd0); k_z = 1; end
    if (udc && kind == 3'd0) begin m_dc = ((sa % 16) + (sb % 16)) > 15; k_dc = 1; end
    if (udc && kind == 3'd1) begin m_dc = (sa % 16) >= (sb % 16); k_dc = 1; end
    if (uc) begin
      if (kind == 3'd0) begin m_c = (sa + sb) > 255; k_c = 1; end
      else if (kind == 3'd1) begin m_c = sa >= sb; k_c = 1; end
      else if (kind == 3'd3) begin m_c = a[7]; k_c = 1; end
      else if (kind == 3'd4) begin m_c = a[0]; k_c = 1; end
    end
    if (tmo) m_to = 0; else if (clr || slp) m_to = 1;
    if (slp) m_pd = 0; else if (clr) m_pd = 1;
    cur_tag = tag;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state compared at first cyc
    cyc("R2 R3 write", 1, 8'hE7, 2, 0, 0, 0,0,0, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R11 ind",     0, 8'h00, 2, 0, 0, 0,0,0, 0,0,0, 1, 7'h00, 8'hA5);
    cyc("R11 dir",     0, 8'h00, 2, 0, 0, 0,0,0, 0,0,0, 0, 7'h7F, 8'h00);
    cyc("R3 wr0",      1, 8'h18, 2, 8'h01, 8'h01, 0,0,0, 0,0,0, 0, 7'h10, 8'h00);
    cyc("R2 set",      1, 8'hA7, 2, 0, 0, 0,0,0, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R4 clear",    1, 8'h00, 2, 8'h00, 8'h00, 1,0,0, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R5 add cy",   0, 8'h00, 0, 8'h8F, 8'h71, 1,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R5 add nc",   0, 8'h00, 0, 8'h12, 8'h34, 1,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R4 lockwr",   1, 8'hFF, 0, 8'hFF, 8'h01, 0,0,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R6 sub ok",   0, 8'h00, 1, 8'h50, 8'h30, 1,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R6 sub brw",  0, 8'h00, 1, 8'h30, 8'h51, 1,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R6 sub eq",   0, 8'h00, 1, 8'h44, 8'h44, 1,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R7 rl",       0, 8'h00, 3, 8'h80, 8'h00, 0,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R7 rr",       0, 8'h00, 4, 8'h02, 8'h00, 0,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R7 logic c",  0, 8'h00, 2, 8'h0F, 8'hF0, 0,1,1, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R8 z1",       0, 8'h00, 2, 8'hF0, 8'h0F, 1,0,0, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R8 z0",       0, 8'h00, 2, 8'hF0, 8'h10, 1,0,0, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R12 hold",    0, 8'h00, 0, 8'hFF, 8'hFF, 1,0,0, 0,0,0, 0, 7'h00, 8'h00);
    cyc("R10 sleep",   0, 8'h00, 2, 0, 0, 0,0,0, 0,1,0, 0, 7'h00, 8'h00);
    cyc("R9 tmo",      0, 8'h00, 2, 0, 0, 0,0,0, 0,0,1, 0, 7'h00, 8'h00);
    cyc("R9 R10 clr",  0, 8'h00, 2, 0, 0, 0,0,0, 1,0,0, 0, 7'h00, 8'h00);
    cyc("R9 tmo+clr",  0, 8'h00, 2, 0, 0, 0,0,0, 1,0,1, 0, 7'h00, 8'h00);
    cyc("R10 slp+clr", 0, 8'h00, 2, 0, 0, 0,0,0, 1,1,0, 0, 7'h00, 8'h00);
    cyc("R3 wr ones",  1, 8'hFF, 2, 0, 0, 0,0,0, 0,0,0, 0, 7'h00, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      cyc("R12 random", ($urandom % 4) == 0, 8'($urandom), 3'($urandom % 5),
          8'($urandom), 8'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
          ($urandom % 3) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
          ($urandom % 8) == 0, 1'($urandom), 7'($urandom), 8'($urandom));
    end
    @(negedge clk);
    cmp_status();
    summary();
    $finish;
  end
endmodule